// File: doc/BRIEF.md
# Retention-Aware Fine-Granularity Refresh Sequencer

This block lives inside a memory controller and decides, once per refresh slot, which auto-refresh command or commands to send. A countdown driven by a time-base tick opens a refresh slot after a fixed number of ticks. In each slot the block reads a preloaded weak-row table. The table returns one flag for each half of the row group that is due next. From those two flags the block chooses one of three actions: one coarse refresh of the whole group, two half-group commands, or a counter-advance with no refresh at all.

When exactly one half holds a weak row, the two half-group commands work as follows. The weak half gets a real fine refresh. The other half gets a counter-advance at fine granularity, so the device's internal row counter stays aligned without refreshing rows that do not need it. The block keeps its own mirror of that internal row counter.

Commands are presented on a two-bit type field, together with a granularity flag and the mirrored row address. Each command is held until the command scheduler acknowledges it. Refresh slots that open while a sequence is still in progress are queued, not lost.

Top module: `rtn_refresh_seq`

## Requirements
- R1: After reset the command type is 2'b00 (idle), busy is low, the lookup enable is low and the mirrored row address is 0.
- R2: A refresh slot opens on every SLOT_TICKS-th tick pulse. No lookup or command happens before that tick.
- R3: Each slot produces a single-cycle lookup pulse whose group index equals the mirrored row address divided by 4. The table answers one cycle later with two flags: bit 0 for the lower half (the first two rows) and bit 1 for the upper half (the last two rows).
- R4: Flags 2'b00 give exactly one command of type 2'b11 (counter advance) with the granularity flag low, at the group's base row.
- R5: Flags 2'b11 give exactly one command of type 2'b01 (coarse refresh) with the granularity flag low, at the group's base row.
- R6: Flags 2'b01 or 2'b10 give two commands, both with the granularity flag high. The lower half is issued first, at the base row, and the upper half second, at base row + 2. The weak half is type 2'b10 (fine refresh) and the other half is type 2'b11.
- R7: A command, its granularity flag and its row are held with busy high until ack is sampled high. An ack while busy is low has no effect.
- R8: The row mirror advances by 4 after an acknowledged full-group command and by 2 after each acknowledged half-group command, and wraps to 0 at ROWS.
- R9: Slots that open while a sequence is pending are queued. Each slot yields exactly one group sequence, in order, as long as fewer than 2^PEND_W - 1 slots are outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Time-base tick pulse feeding the slot countdown |
| lkup_en_o | output | 1 | Weak-row table read strobe |
| lkup_grp_o | output | $clog2(ROWS)-2 | Row group index being read |
| lkup_weak_i | input | 2 | Weak flags, one cycle after the strobe (bit 0 lower half) |
| cmd_type_o | output | 2 | 00 idle, 01 coarse, 10 fine, 11 counter advance |
| cmd_half_o | output | 1 | High when the command covers half a group |
| cmd_row_o | output | $clog2(ROWS) | Mirrored row address of the command |
| busy_o | output | 1 | A command is presented and awaits ack |
| ack_i | input | 1 | Scheduler acknowledge of the presented command |

## Verification
The assertions take three things for granted about the inputs. First, the weak-row table answers exactly one cycle after each read strobe. Second, the scheduler never lets the queue of outstanding slots reach its saturation value. Third, tick pulses are single-cycle strobes. The bench meets the first by modelling the table as a registered read of a fixed array. It meets the second by queuing at most three slots at once. Random tick gaps and random ack delays then vary the spacing between slots and commands without leaving these bounds.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef enum logic [1:0] {
    CMD_NONE   = 2'b00,
    CMD_COARSE = 2'b01,
    CMD_FINE   = 2'b10,
    CMD_ADV    = 2'b11
  } rr_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_DATA,
    ST_FIRST,
    ST_LAST
  } rr_state_e;

  typedef struct packed {
    rr_cmd_e first;
    rr_cmd_e second;
    logic    split;
  } rr_plan_t;
endpackage

// File: rtl/rr_slot_timer.sv
module rr_slot_timer #(
  parameter int SLOT_TICKS = 4,
  parameter int PEND_W     = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic take_i,
  output logic pend_o
);
  localparam int CW = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(SLOT_TICKS - 1);
  localparam logic [PEND_W-1:0] PMAX = {PEND_W{1'b1}};

  logic [CW-1:0]     cnt_q;
  logic [PEND_W-1:0] pend_q;
  logic              slot;

  assign slot   = tick_i && (cnt_q == '0);
  assign pend_o = (pend_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RELOAD;
    end else if (tick_i) begin
      cnt_q <= (cnt_q == '0) ? RELOAD : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else begin
      case ({slot, take_i})
        2'b10:   if (pend_q != PMAX) pend_q <= pend_q + 1'b1;
        2'b01:   pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q;
      endcase
    end
  end

  AST_PEND_ROOM: assert property (@(posedge clk) disable iff (rst)
    slot |-> (pend_q != PMAX) || take_i); // R9
  AST_TAKE_VALID: assert property (@(posedge clk) disable iff (rst)
    take_i |-> pend_q != '0); // R9
  AST_SLOT_QUEUED: assert property (@(posedge clk) disable iff (rst)
    (slot && !take_i) |=> pend_q != '0); // R9
endmodule

// File: rtl/rr_plan.sv
module rr_plan
  import rr_pkg::*;
(
  input  logic [1:0] weak_i,
  output rr_plan_t   plan_o
);
  always_comb begin
    plan_o = '{first: CMD_ADV, second: CMD_NONE, split: 1'b0};
    case (weak_i)
      2'b00: plan_o = '{first: CMD_ADV,    second: CMD_NONE, split: 1'b0};
      2'b11: plan_o = '{first: CMD_COARSE, second: CMD_NONE, split: 1'b0};
      2'b01: plan_o = '{first: CMD_FINE,   second: CMD_ADV,  split: 1'b1};
      2'b10: plan_o = '{first: CMD_ADV,    second: CMD_FINE, split: 1'b1};
      default: ;
    endcase
  end
endmodule

// File: rtl/rr_row_mirror.sv
module rr_row_mirror #(
  parameter int ROWS = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv_i,
  input  logic                    half_i,
  output logic [$clog2(ROWS)-1:0] row_o
);
  localparam int RW = $clog2(ROWS);
  localparam logic [RW:0] LIMIT = (RW+1)'(ROWS);

  logic [RW:0] sum;
  logic [RW:0] nxt;

  assign sum = {1'b0, row_o} + (half_i ? (RW+1)'(2) : (RW+1)'(4));
  assign nxt = (sum >= LIMIT) ? sum - LIMIT : sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_o <= '0;
    end else if (adv_i) begin
      row_o <= nxt[RW-1:0];
    end
  end

  AST_ROW_MOVES: assert property (@(posedge clk) disable iff (rst)
    adv_i |=> row_o != $past(row_o)); // R8
  AST_ROW_STILL: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(row_o)); // R8
endmodule

// File: rtl/rtn_refresh_seq.sv
module rtn_refresh_seq
  import rr_pkg::*;
#(
  parameter int ROWS       = 64,
  parameter int SLOT_TICKS = 4,
  parameter int PEND_W     = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick_i,
  output logic                    lkup_en_o,
  output logic [$clog2(ROWS)-3:0] lkup_grp_o,
  input  logic [1:0]              lkup_weak_i,
  output logic [1:0]              cmd_type_o,
  output logic                    cmd_half_o,
  output logic [$clog2(ROWS)-1:0] cmd_row_o,
  output logic                    busy_o,
  input  logic                    ack_i
);
  localparam int RW = $clog2(ROWS);

  rr_state_e      state_q;
  rr_cmd_e        cmd_q;
  rr_cmd_e        second_q;
  logic           half_q;
  logic           busy_q;
  logic           lkup_q;
  logic [RW-3:0]  grp_q;
  logic           pend_nz;
  logic           take;
  logic           adv;
  logic [RW-1:0]  row;
  rr_plan_t       plan;

  assign take = (state_q == ST_IDLE) && pend_nz;
  assign adv  = ack_i && ((state_q == ST_FIRST) || (state_q == ST_LAST));

  rr_slot_timer #(.SLOT_TICKS(SLOT_TICKS), .PEND_W(PEND_W)) u_timer (
    .clk(clk), .rst(rst), .tick_i(tick_i), .take_i(take), .pend_o(pend_nz)
  );

  rr_plan u_plan (.weak_i(lkup_weak_i), .plan_o(plan));

  rr_row_mirror #(.ROWS(ROWS)) u_mirror (
    .clk(clk), .rst(rst), .adv_i(adv), .half_i(half_q), .row_o(row)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cmd_q    <= CMD_NONE;
      second_q <= CMD_NONE;
      half_q   <= 1'b0;
      busy_q   <= 1'b0;
      lkup_q   <= 1'b0;
      grp_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (take) begin
            lkup_q  <= 1'b1;
            grp_q   <= row[RW-1:2];
            state_q <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          lkup_q  <= 1'b0;
          state_q <= ST_DATA;
        end
        ST_DATA: begin
          cmd_q    <= plan.first;
          second_q <= plan.second;
          half_q   <= plan.split;
          busy_q   <= 1'b1;
          state_q  <= plan.split ? ST_FIRST : ST_LAST;
        end
        ST_FIRST: begin
          if (ack_i) begin
            cmd_q   <= second_q;
            state_q <= ST_LAST;
          end
        end
        ST_LAST: begin
          if (ack_i) begin
            cmd_q   <= CMD_NONE;
            half_q  <= 1'b0;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign lkup_en_o  = lkup_q;
  assign lkup_grp_o = grp_q;
  assign cmd_type_o = cmd_q;
  assign cmd_half_o = half_q;
  assign cmd_row_o  = row;
  assign busy_o     = busy_q;

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !ack_i) |=> busy_o && $stable(cmd_type_o) && $stable(cmd_row_o) && $stable(cmd_half_o)); // R7
  AST_LKUP_PULSE: assert property (@(posedge clk) disable iff (rst)
    lkup_en_o |=> !lkup_en_o); // R3
  AST_COARSE_FULL: assert property (@(posedge clk) disable iff (rst)
    (cmd_type_o == CMD_COARSE) |-> !cmd_half_o); // R5
  AST_HALVES_DIFFER: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FIRST && ack_i) |=> busy_o && cmd_half_o && (cmd_type_o != $past(cmd_type_o))); // R6
  AST_ROW_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> (row[1:0] == 2'b00)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (cmd_type_o == CMD_NONE)); // R1
endmodule

// File: tb/sim_rtn_refresh_seq.sv
module sim_rtn_refresh_seq;
  localparam int ROWS   = 64;
  localparam int SLOTT  = 4;
  localparam int PEND_W = 3;
  localparam int RW     = $clog2(ROWS);
  localparam int GROUPS = ROWS / 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0;
  logic ack_i = 1'b0;
  logic lkup_en_o;
  logic [RW-3:0] lkup_grp_o;
  logic [1:0] lkup_weak_i;
  logic [1:0] cmd_type_o;
  logic cmd_half_o;
  logic [RW-1:0] cmd_row_o;
  logic busy_o;

  always #2 clk = ~clk;

  rtn_refresh_seq #(.ROWS(ROWS), .SLOT_TICKS(SLOTT), .PEND_W(PEND_W)) u0 (
    .clk(clk), .rst(rst), .tick_i(tick_i), .lkup_en_o(lkup_en_o),
    .lkup_grp_o(lkup_grp_o), .lkup_weak_i(lkup_weak_i), .cmd_type_o(cmd_type_o),
    .cmd_half_o(cmd_half_o), .cmd_row_o(cmd_row_o), .busy_o(busy_o), .ack_i(ack_i)
  );

  logic [1:0] tbl [GROUPS];
  always_ff @(posedge clk) if (lkup_en_o) lkup_weak_i <= tbl[lkup_grp_o];

  int checks = 0;
  int fails = 0;
  int model_row = 0;
  bit saw_lkup = 0;
  int lkup_cnt = 0;
  int last_grp = -1;

  always @(negedge clk) begin
    if (!rst && lkup_en_o) begin
      saw_lkup = 1;
      lkup_cnt++;
      last_grp = int'(lkup_grp_o);
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic ticks(input int n, input int gap_max);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
      repeat ($urandom_range(0, gap_max)) @(negedge clk);
    end
  endtask

  function automatic int exp_type(input logic [1:0] f, input int k);
    if (f == 2'b00) return 3;
    if (f == 2'b11) return 1;
    if (k == 0) return f[0] ? 2 : 3;
    return f[1] ? 2 : 3;
  endfunction

  task automatic serve_one(input int ack_max);
    int w;
    int base;
    int n;
    logic [1:0] f;
    w = 0;
    while (!busy_o && w < 100) begin @(negedge clk); w++; end
    chk(busy_o == 1'b1, "R9", "command appears for slot", int'(busy_o), 1);
    base = model_row;
    f = tbl[base/4];
    chk(last_grp == base/4, "R3", "lookup group index", last_grp, base/4);
    n = (f == 2'b01 || f == 2'b10) ? 2 : 1;
    for (int k = 0; k < n; k++) begin
      string rq;
      rq = (n == 2) ? "R6" : ((f == 2'b00) ? "R4" : "R5");
      chk(int'(cmd_type_o) == exp_type(f, k), rq, "command type", int'(cmd_type_o), exp_type(f, k));
      chk(cmd_half_o == (n == 2), rq, "granularity flag", int'(cmd_half_o), int'(n == 2));
      chk(int'(cmd_row_o) == base + 2*k, "R8", "command row", int'(cmd_row_o), base + 2*k);
      w = $urandom_range(0, ack_max);
      if (w > 0) begin
        repeat (w) @(negedge clk);
        chk(busy_o && int'(cmd_type_o) == exp_type(f, k), "R7", "held until ack", int'(cmd_type_o), exp_type(f, k));
      end
      ack_i = 1'b1;
      @(negedge clk) ack_i = 1'b0;
    end
    chk(busy_o == 1'b0, "R7", "busy drops after last ack", int'(busy_o), 0);
    model_row = (base + 4) % ROWS;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int g = 0; g < GROUPS; g++) tbl[g] = 2'($urandom_range(0, 3));
    tbl[1] = 2'b00; tbl[2] = 2'b11; tbl[3] = 2'b01; tbl[4] = 2'b10;
    tbl[GROUPS-1] = 2'b10;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_type_o == 2'b00, "R1", "reset command type", int'(cmd_type_o), 0);
    chk(busy_o == 1'b0, "R1", "reset busy", int'(busy_o), 0);
    chk(lkup_en_o == 1'b0, "R1", "reset lookup", int'(lkup_en_o), 0);
    chk(cmd_row_o == '0, "R1", "reset row", int'(cmd_row_o), 0);

    // R2: one tick short of a slot produces nothing
    saw_lkup = 0;
    ticks(SLOTT - 1, 0);
    repeat (8) @(negedge clk);
    chk(saw_lkup == 0, "R2", "no lookup before slot", int'(saw_lkup), 0);
    chk(busy_o == 1'b0, "R2", "no command before slot", int'(busy_o), 0);
    ticks(1, 0);
    repeat (4) @(negedge clk);
    chk(saw_lkup == 1, "R2", "lookup on slot tick", int'(saw_lkup), 1);
    serve_one(2);

    // directed groups 1..4: R4, R5, R6 both orders
    for (int i = 0; i < 4; i++) begin
      ticks(SLOTT, 1);
      serve_one(3);
    end

    // R7: ack while idle has no effect
    repeat (3) @(negedge clk);
    ack_i = 1'b1;
    @(negedge clk) ack_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy_o == 1'b0 && cmd_row_o == RW'(model_row), "R7", "idle ack row", int'(cmd_row_o), model_row);

    // R9: three slots queued while the first is unacknowledged
    lkup_cnt = 0;
    ticks(3 * SLOTT, 0);
    for (int i = 0; i < 3; i++) serve_one(1);
    saw_lkup = 0;
    repeat (20) @(negedge clk);
    chk(saw_lkup == 0 && busy_o == 1'b0, "R9", "no extra sequence", int'(saw_lkup), 0);
    chk(lkup_cnt == 3, "R9", "one lookup per slot", lkup_cnt, 3);

    // random phase, wraps the row mirror (R8)
    for (int i = 0; i < 40; i++) begin
      ticks(SLOTT, 3);
      serve_one(4);
    end
    chk(model_row >= 0 && int'(cmd_row_o) == model_row, "R8", "row after wraps", int'(cmd_row_o), model_row);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule